// File: doc/BRIEF.md
# Paged Backplane Master Window

This block lets a local processor reach a 16-bit parallel backplane through a 64 KB memory window. A local memory access whose address bits 23:16 equal 0x0E is forwarded to the backplane. The low 16 bits of the backplane address come straight from the local address. The six bits above them come from a page register that software sets through I/O ports. The backplane side is a plain request/acknowledge/error handshake.

Window writes are posted. The local cycle is acknowledged at once, and software polls a DONE status bit to learn when the backplane cycle has finished. A bus error sets a sticky flag, which can raise an interrupt. A locked window read opens a read-modify-write pair. The backplane address strobe then stays asserted until the next window access, taken as the write, completes. Inbound backplane slave accesses are held off while the processor runs locked cycles to local DRAM.

Top module: `bp_page_window`

## Requirements
- R1: A memory access (lb_io_i=0) whose lb_addr_i[23:16] is 0x0E is forwarded with bp_addr_o = {page, lb_addr_i[15:0]}, using the page value held when the access is accepted. Any other memory address produces no lb_ack_o and no bp_req_o.
- R2: The page register is written and read at I/O port 0x8130 and at its aliases 0x8132, 0x8134 and 0x8136. It uses bits 5:0, and a read returns zero in bits 15:6.
- R3: A window write is acknowledged to the local side one cycle after it is accepted, without waiting for the backplane. bp_req_o then stays high, with address, data and direction stable, until bp_ack_i or bp_err_i.
- R4: The status port 0x8156 reads bit 7 (DONE) as 0 while a backplane access is outstanding or a read-modify-write pair is open, and as 1 otherwise.
- R5: bp_err_i during a request sets status bit 1 (bus error). The bit stays set until a status write has bit 1 equal to 1; writing 0 to it has no effect. Status bit 0 is a read/write interrupt enable, and irq_o is high when both bits are 1.
- R6: A window read holds off lb_ack_o until the backplane answers and returns bp_rdata_i. A read that ends in a bus error returns 0xFFFF.
- R7: A window access arriving while a posted write is pending is not issued on the backplane until that write has been acknowledged.
- R8: A locked window read opens a read-modify-write pair. bp_as_o stays high from the read through the next window access, and drops once that access completes.
- R9: sl_stall_o is high from the acceptance of a locked memory access outside the window until lb_lock_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lb_req_i | input | 1 | Local request, held until lb_ack_o |
| lb_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| lb_we_i | input | 1 | Local write |
| lb_lock_i | input | 1 | Local locked-cycle indication |
| lb_addr_i | input | 24 | Local address |
| lb_wdata_i | input | 16 | Local write data |
| lb_ack_o | output | 1 | One-cycle acknowledge |
| lb_rdata_o | output | 16 | Read data, valid with lb_ack_o |
| bp_req_o | output | 1 | Backplane cycle request |
| bp_we_o | output | 1 | Backplane write |
| bp_as_o | output | 1 | Backplane address strobe |
| bp_addr_o | output | 22 | Backplane address |
| bp_wdata_o | output | 16 | Backplane write data |
| bp_rdata_i | input | 16 | Backplane read data |
| bp_ack_i | input | 1 | Backplane cycle complete |
| bp_err_i | input | 1 | Backplane bus error |
| sl_stall_o | output | 1 | Hold inbound slave accesses |
| irq_o | output | 1 | Bus-error interrupt |

## Verification
The assertions assume a local requester that keeps lb_req_i and its qualifiers steady until lb_ack_o and then drops the request, so an access is never accepted twice. They also assume that bp_ack_i and bp_err_i pulse for one cycle, only while bp_req_o is high. The access that closes a read-modify-write pair is taken to be a write. The bench drives every local access through one task that follows this handshake. Its backplane responder answers each request exactly once after a random delay, and every locked window read is followed by a window write.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  localparam int unsigned LA_W   = 24;
  localparam int unsigned DW     = 16;
  localparam int unsigned OFF_W  = 16;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RMW} seq_st_e;
endpackage

// File: rtl/bpw_decode.sv
module bpw_decode #(
  parameter int unsigned LA_W      = 24,
  parameter int unsigned OFF_W     = 16,
  parameter logic [7:0]  WIN_TAG   = 8'h0E,
  parameter logic [15:0] PAGE_PORT = 16'h8130,
  parameter logic [15:0] STAT_PORT = 16'h8156
) (
  input  logic            io_i,
  input  logic [LA_W-1:0] addr_i,
  output logic            win_hit_o,
  output logic            page_hit_o,
  output logic            stat_hit_o,
  output logic            dram_hit_o
);
  localparam int unsigned TAG_W = LA_W - OFF_W;
  logic tag_match;
  assign tag_match  = (addr_i[LA_W-1:OFF_W] == TAG_W'(WIN_TAG));
  assign win_hit_o  = !io_i && tag_match;
  assign dram_hit_o = !io_i && !tag_match;
  // base plus three aliases on even ports within one 8-byte group
  assign page_hit_o = io_i && (addr_i[15:3] == PAGE_PORT[15:3]) && !addr_i[0];
  assign stat_hit_o = io_i && (addr_i[15:0] == STAT_PORT);
endmodule

// File: rtl/bpw_regs.sv
module bpw_regs #(
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_wr_i,
  input  logic              stat_wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              err_set_i,
  input  logic              done_i,
  input  logic              sel_stat_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [DW-1:0]     rd_val_o,
  output logic              irq_o
);
  logic [PAGE_W-1:0] page_q;
  logic              berr_q, irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      berr_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (page_wr_i) page_q <= wdata_i[PAGE_W-1:0];
      if (stat_wr_i) irq_en_q <= wdata_i[0];
      if (err_set_i)                   berr_q <= 1'b1;
      else if (stat_wr_i && wdata_i[1]) berr_q <= 1'b0;
    end
  end

  logic [DW-1:0] stat_val;
  always_comb begin
    stat_val    = '0;
    stat_val[7] = done_i;
    stat_val[1] = berr_q;
    stat_val[0] = irq_en_q;
  end

  assign page_o   = page_q;
  assign rd_val_o = sel_stat_i ? stat_val : DW'(page_q);
  assign irq_o    = berr_q && irq_en_q;

  // R5
  berr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_q && !(stat_wr_i && wdata_i[1]) |=> berr_q);
  // R5
  berr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> berr_q);
endmodule

// File: rtl/bpw_seq.sv
module bpw_seq
  import bpw_pkg::*;
#(
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned DW     = 16,
  parameter int unsigned LA_W   = 24,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned BA_W  = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lb_req_i,
  input  logic              lb_we_i,
  input  logic              lb_lock_i,
  input  logic [LA_W-1:0]   lb_addr_i,
  input  logic [DW-1:0]     lb_wdata_i,
  input  logic              win_hit_i,
  input  logic              reg_hit_i,
  input  logic              dram_hit_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DW-1:0]     reg_rdata_i,
  output logic              reg_wr_o,
  output logic              lb_ack_o,
  output logic [DW-1:0]     lb_rdata_o,
  output logic              bp_req_o,
  output logic              bp_we_o,
  output logic              bp_as_o,
  output logic [BA_W-1:0]   bp_addr_o,
  output logic [DW-1:0]     bp_wdata_o,
  input  logic [DW-1:0]     bp_rdata_i,
  input  logic              bp_ack_i,
  input  logic              bp_err_i,
  output logic              err_set_o,
  output logic              done_o,
  output logic              sl_stall_o
);
  seq_st_e         st_q;
  logic            ack_q, req_q, we_q, lock_rd_q, dram_lock_q;
  logic [BA_W-1:0] addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic            io_ok, win_ok, resp, dram_lock_acc;

  assign resp   = req_q && (bp_ack_i || bp_err_i);
  assign io_ok  = lb_req_i && !ack_q && reg_hit_i && (st_q != ST_RD);
  assign win_ok = lb_req_i && !ack_q && win_hit_i &&
                  (st_q == ST_IDLE || st_q == ST_RMW);
  assign dram_lock_acc = lb_req_i && lb_lock_i && dram_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ack_q     <= 1'b0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      lock_rd_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      if (io_ok) begin
        ack_q   <= 1'b1;
        rdata_q <= reg_rdata_i;
      end
      unique case (st_q)
        ST_IDLE, ST_RMW: if (win_ok) begin
          addr_q    <= {page_i, lb_addr_i[OFF_W-1:0]};
          we_q      <= lb_we_i;
          wdata_q   <= lb_wdata_i;
          req_q     <= 1'b1;
          lock_rd_q <= lb_lock_i && !lb_we_i && (st_q == ST_IDLE);
          if (lb_we_i) begin
            ack_q <= 1'b1;  // posted
            st_q  <= ST_WR;
          end else begin
            st_q  <= ST_RD;
          end
        end
        ST_RD: if (resp) begin
          req_q   <= 1'b0;
          ack_q   <= 1'b1;
          rdata_q <= bp_err_i ? '1 : bp_rdata_i;
          st_q    <= lock_rd_q ? ST_RMW : ST_IDLE;
        end
        ST_WR: if (resp) begin
          req_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            dram_lock_q <= 1'b0;
    else if (!lb_lock_i)    dram_lock_q <= 1'b0;
    else if (dram_lock_acc) dram_lock_q <= 1'b1;
  end

  assign reg_wr_o   = io_ok && lb_we_i;
  assign lb_ack_o   = ack_q;
  assign lb_rdata_o = rdata_q;
  assign bp_req_o   = req_q;
  assign bp_we_o    = we_q;
  assign bp_addr_o  = addr_q;
  assign bp_wdata_o = wdata_q;
  assign bp_as_o    = req_q || (st_q == ST_RMW);
  assign err_set_o  = req_q && bp_err_i;
  assign done_o     = (st_q == ST_IDLE);
  assign sl_stall_o = dram_lock_q || dram_lock_acc;

  // R3
  bp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_req_o && !bp_ack_i && !bp_err_i |=>
      bp_req_o && $stable(bp_addr_o) && $stable(bp_wdata_o) && $stable(bp_we_o));
  // R8
  rmw_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) && lock_rd_q && resp |=> bp_as_o && !bp_req_o);
  // R7
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR) |=> !(bp_req_o && !bp_we_o));
  // R3
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_ack_o |=> !lb_ack_o);
endmodule

// File: rtl/bp_page_window.sv
module bp_page_window
  import bpw_pkg::*;
#(
  parameter int unsigned PAGE_W    = 6,
  parameter logic [7:0]  WIN_TAG   = 8'h0E,
  parameter logic [15:0] PAGE_PORT = 16'h8130,
  parameter logic [15:0] STAT_PORT = 16'h8156,
  localparam int unsigned BA_W     = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lb_req_i,
  input  logic              lb_io_i,
  input  logic              lb_we_i,
  input  logic              lb_lock_i,
  input  logic [LA_W-1:0]   lb_addr_i,
  input  logic [DW-1:0]     lb_wdata_i,
  output logic              lb_ack_o,
  output logic [DW-1:0]     lb_rdata_o,
  output logic              bp_req_o,
  output logic              bp_we_o,
  output logic              bp_as_o,
  output logic [BA_W-1:0]   bp_addr_o,
  output logic [DW-1:0]     bp_wdata_o,
  input  logic [DW-1:0]     bp_rdata_i,
  input  logic              bp_ack_i,
  input  logic              bp_err_i,
  output logic              sl_stall_o,
  output logic              irq_o
);
  logic win_hit, page_hit, stat_hit, dram_hit, reg_wr, err_set, done;
  logic [PAGE_W-1:0] page;
  logic [DW-1:0]     reg_rdata;

  bpw_decode #(.LA_W(LA_W), .OFF_W(OFF_W), .WIN_TAG(WIN_TAG),
               .PAGE_PORT(PAGE_PORT), .STAT_PORT(STAT_PORT)) u_decode (
    .io_i(lb_io_i), .addr_i(lb_addr_i), .win_hit_o(win_hit),
    .page_hit_o(page_hit), .stat_hit_o(stat_hit), .dram_hit_o(dram_hit));

  bpw_regs #(.PAGE_W(PAGE_W), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .page_wr_i(reg_wr && page_hit), .stat_wr_i(reg_wr && stat_hit),
    .wdata_i(lb_wdata_i), .err_set_i(err_set), .done_i(done),
    .sel_stat_i(stat_hit), .page_o(page), .rd_val_o(reg_rdata), .irq_o(irq_o));

  bpw_seq #(.PAGE_W(PAGE_W), .DW(DW), .LA_W(LA_W), .OFF_W(OFF_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .lb_req_i(lb_req_i), .lb_we_i(lb_we_i),
    .lb_lock_i(lb_lock_i), .lb_addr_i(lb_addr_i), .lb_wdata_i(lb_wdata_i),
    .win_hit_i(win_hit), .reg_hit_i(page_hit || stat_hit), .dram_hit_i(dram_hit),
    .page_i(page), .reg_rdata_i(reg_rdata), .reg_wr_o(reg_wr),
    .lb_ack_o(lb_ack_o), .lb_rdata_o(lb_rdata_o), .bp_req_o(bp_req_o),
    .bp_we_o(bp_we_o), .bp_as_o(bp_as_o), .bp_addr_o(bp_addr_o),
    .bp_wdata_o(bp_wdata_o), .bp_rdata_i(bp_rdata_i), .bp_ack_i(bp_ack_i),
    .bp_err_i(bp_err_i), .err_set_o(err_set), .done_o(done),
    .sl_stall_o(sl_stall_o));
endmodule

// File: tb/bp_page_window_bench.sv
module bp_page_window_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lb_req = 0, lb_io = 0, lb_we = 0, lb_lock = 0;
  logic [23:0] lb_addr = '0;
  logic [15:0] lb_wdata = '0;
  logic lb_ack, bp_req, bp_we, bp_as, sl_stall, irq;
  logic [15:0] lb_rdata, bp_wdata, bp_rdata;
  logic [21:0] bp_addr;
  logic bp_ack = 0, bp_err = 0;

  int errors = 0, checks = 0;
  int delay = 2, cnt = 0, txn_cnt = 0;
  bit inj_err = 0;
  logic [21:0] last_addr;
  logic [15:0] last_data;
  logic        last_we;
  logic        we_hist [256];

  always #5 clk = ~clk;

  bp_page_window u_bp_page_window (
    .clk_i(clk), .rst_ni(rst_n), .lb_req_i(lb_req), .lb_io_i(lb_io),
    .lb_we_i(lb_we), .lb_lock_i(lb_lock), .lb_addr_i(lb_addr),
    .lb_wdata_i(lb_wdata), .lb_ack_o(lb_ack), .lb_rdata_o(lb_rdata),
    .bp_req_o(bp_req), .bp_we_o(bp_we), .bp_as_o(bp_as), .bp_addr_o(bp_addr),
    .bp_wdata_o(bp_wdata), .bp_rdata_i(bp_rdata), .bp_ack_i(bp_ack),
    .bp_err_i(bp_err), .sl_stall_o(sl_stall), .irq_o(irq));

  function automatic logic [15:0] model_rd(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'h15B};
  endfunction
  assign bp_rdata = model_rd(bp_addr);

  // backplane responder: one answer per request after 'delay' cycles
  always @(negedge clk) begin
    if (bp_ack || bp_err) begin
      bp_ack <= 0; bp_err <= 0;
    end else if (bp_req) begin
      if (cnt >= delay) begin
        last_addr = bp_addr; last_data = bp_wdata; last_we = bp_we;
        we_hist[txn_cnt % 256] = bp_we;
        txn_cnt++;
        if (inj_err) bp_err <= 1; else bp_ack <= 1;
        cnt = 0;
      end else cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit io, input bit we, input bit lock,
                     input logic [23:0] a, input logic [15:0] d,
                     output logic [15:0] rd);
    @(negedge clk);
    lb_io = io; lb_we = we; lb_lock = lock; lb_addr = a; lb_wdata = d; lb_req = 1;
    do @(negedge clk); while (!lb_ack);
    rd = lb_rdata;
    lb_req = 0;
  endtask

  task automatic rd_stat(output logic [15:0] s);
    acc(1, 0, 0, 24'h008156, 16'h0, s);
  endtask

  task automatic wait_done();
    logic [15:0] s;
    do rd_stat(s); while (!s[7]);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r, s;
    int mark;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R3 reset req", {bp_req, bp_as, lb_ack}, 0);
    chk("R5 reset irq", {irq, sl_stall}, 0);
    rd_stat(s);
    chk("R4 reset done", s[7], 1);
    chk("R5 reset berr", s[1], 0);

    // R2 page via alias
    acc(1, 1, 0, 24'h008134, 16'hFFEA, r);
    acc(1, 0, 0, 24'h008130, 16'h0, r);
    chk("R2 alias write/base read", r, 16'h002A);
    acc(1, 1, 0, 24'h008136, 16'h0011, r);
    acc(1, 0, 0, 24'h008132, 16'h0, r);
    chk("R2 alias read", r, 16'h0011);
    acc(1, 1, 0, 24'h008130, 16'h002A, r);

    // R3 posted write, R4 DONE low while pending
    delay = 8;
    acc(0, 1, 0, 24'h0E1234, 16'hBEEF, r);
    chk("R3 ack before backplane done", bp_req, 1);
    rd_stat(s);
    chk("R4 done low while pending", s[7], 0);
    acc(1, 1, 0, 24'h008130, 16'h0005, r);  // page change after acceptance
    wait_done();
    chk("R1 window address", last_addr, {6'h2A, 16'h1234});
    chk("R1 write data", {last_we, last_data}, {1'b1, 16'hBEEF});

    // R6 read
    delay = 3;
    acc(0, 0, 0, 24'h0E00F0, 16'h0, r);
    chk("R6 read data", r, model_rd({6'h05, 16'h00F0}));

    // R1 outside window: no ack, no request
    @(negedge clk);
    lb_io = 0; lb_we = 0; lb_lock = 0; lb_addr = 24'h0D4000; lb_req = 1;
    repeat (8) begin
      @(negedge clk);
      if (lb_ack || bp_req) break;
    end
    chk("R1 outside window ignored", {lb_ack, bp_req}, 0);
    lb_req = 0;

    // R7 read behind posted write
    delay = 5;
    mark = txn_cnt;
    acc(0, 1, 0, 24'h0E0100, 16'h1111, r);
    acc(0, 0, 0, 24'h0E0200, 16'h0, r);
    chk("R7 first txn write", we_hist[mark % 256], 1);
    chk("R7 second txn read", we_hist[(mark + 1) % 256], 0);
    chk("R7 read data", r, model_rd({6'h05, 16'h0200}));

    // R5 bus error, sticky, write-1-to-clear, irq
    inj_err = 1;
    acc(0, 1, 0, 24'h0E0010, 16'h5555, r);
    wait_done();
    inj_err = 0;
    rd_stat(s);
    chk("R5 berr set", s[1], 1);
    chk("R5 no irq when disabled", irq, 0);
    acc(1, 1, 0, 24'h008156, 16'h0001, r);
    rd_stat(s);
    chk("R5 write 0 keeps berr", s[1:0], 2'b11);
    chk("R5 irq raised", irq, 1);
    acc(1, 1, 0, 24'h008156, 16'h0003, r);
    rd_stat(s);
    chk("R5 write 1 clears berr", s[1:0], 2'b01);
    chk("R5 irq cleared", irq, 0);
    inj_err = 1;
    acc(0, 0, 0, 24'h0E0020, 16'h0, r);
    inj_err = 0;
    chk("R6 error read value", r, 16'hFFFF);
    acc(1, 1, 0, 24'h008156, 16'h0002, r);

    // R8 RMW pair
    delay = 2;
    acc(0, 0, 1, 24'h0E0300, 16'h0, r);
    chk("R8 rmw read data", r, model_rd({6'h05, 16'h0300}));
    chk("R8 as held after read", {bp_as, bp_req}, 2'b10);
    rd_stat(s);
    chk("R4 done low in open pair", s[7], 0);
    chk("R8 as still held", bp_as, 1);
    acc(0, 1, 1, 24'h0E0300, 16'h00AA, r);
    lb_lock = 0;
    chk("R8 as across write", bp_as, 1);
    wait_done();
    chk("R8 as dropped", bp_as, 0);
    chk("R8 closing write", {last_we, last_addr}, {1'b1, 6'h05, 16'h0300});

    // R9 slave stall
    chk("R9 no stall idle", sl_stall, 0);
    @(negedge clk);
    lb_io = 0; lb_we = 0; lb_lock = 1; lb_addr = 24'h021000; lb_req = 1;
    @(negedge clk);
    chk("R9 stall on locked DRAM", sl_stall, 1);
    lb_req = 0;
    repeat (2) @(negedge clk);
    chk("R9 stall while lock held", sl_stall, 1);
    lb_lock = 0;
    @(negedge clk);
    chk("R9 stall released", sl_stall, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [5:0]  pg  = 6'($urandom);
      logic [15:0] off = 16'($urandom);
      logic [15:0] d   = 16'($urandom);
      logic [23:0] prt = 24'h008130 + 24'(2 * ($urandom % 4));
      bit          w   = 1'($urandom);
      delay = int'($urandom % 5);
      acc(1, 1, 0, prt, {10'h3FF, pg}, r);
      if (w) begin
        acc(0, 1, 0, {8'h0E, off}, d, r);
        wait_done();
        chk("R1 rand write", {last_we, last_addr, last_data}, {1'b1, pg, off, d});
      end else begin
        acc(0, 0, 0, {8'h0E, off}, 16'h0, r);
        chk("R6 rand read", r, model_rd({pg, off}));
        chk("R1 rand read addr", last_addr, {pg, off});
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule